// File: doc/BRIEF.md
# Mode-Switched Parallel Port Pair

This block drives two W-bit pin groups, a high port and a low port, whose roles depend on a mode input. In single-chip mode the high port is a pure output port loaded by CPU register writes. It can optionally emit a one-cycle strobe on `strb` after each such write. The low port is a general-purpose bidirectional port with a per-bit direction register. It can optionally run a full handshake: an edge on `stra` captures the pins into an input latch, and reading that latch answers with a strobe on `strb`.

In expanded mode both ports become a multiplexed external bus. A bus cycle requested with `busStart` produces an address phase first. In that phase `addrStrobe` is high, the high port carries the upper address byte and the low port carries the lower address byte. A data phase follows, in which the low port drives write data or floats so that read data can be captured. During expanded mode the high port's data register acts as external address space, so CPU writes to it are dropped.

CPU register map (`regSel`): 0 = high port data, 1 = low port data / input latch, 2 = low port direction, 3 = control/status.

Top module: `ppair_top`

## Requirements
- R1: After reset: `hiOut` = 0, `loOe` = 0, `strb` = 0, `addrStrobe` = 0, and every register reads back 0.
- R2: In single-chip mode `hiOe` is all ones. The cycle after a CPU write to register 0, `hiOut` equals the written value.
- R3: With control bit 0 set, each register-0 write in single-chip mode makes `strb` active for exactly the one cycle after the write. With bit 0 clear, no pulse occurs.
- R4: Control bit 2 sets strobe polarity. With 0, `strb` idles low and pulses high. With 1, `strb` idles high and pulses low.
- R5: Register 2 sets direction per bit, 1 = output, and `loOe` follows it. `loOut` shows register 1. A read of register 1 with handshake off returns pin values on input bits and register values on output bits.
- R6: With handshake on (control bit 1), an active `stra` edge latches `loIn` and sets status bit 7 of register 3. Control bit 3 selects the edge: 1 = rising, 0 = falling. The latch does not change at other times.
- R7: With handshake on, a read of register 1 returns the latch, clears the status flag, and pulses `strb` in the following cycle.
- R8: In expanded mode, the cycle after `busStart` is the address phase. In it `addrStrobe` = 1, `{hiOut, loOut}` = `busAddr` and `loOe` is all ones.
- R9: The cycle after the address phase is the data phase, and `hiOut` still holds the upper address byte. For a write (`busRnW` = 0), `loOe` is all ones and `loOut` = `busWdata`. For a read, `loOe` = 0 and `busRdata` holds `loIn` from the data phase starting the next cycle.
- R10: In expanded mode a CPU write to register 0 neither changes the register nor pulses `strb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| expMode | input | 1 | 1 = expanded multiplexed mode, 0 = single-chip |
| regSel | input | 2 | CPU register select |
| regWr | input | 1 | CPU register write |
| regRd | input | 1 | CPU register read |
| regWdata | input | W | CPU write data |
| regRdata | output | W | CPU read data (combinational) |
| busStart | input | 1 | Start an external bus cycle |
| busRnW | input | 1 | Bus cycle direction, 1 = read |
| busAddr | input | 2W | Bus cycle address |
| busWdata | input | W | Bus write data |
| busRdata | output | W | Captured bus read data |
| addrStrobe | output | 1 | Address phase indicator |
| hiOut | output | W | High port pin output values |
| hiOe | output | W | High port output enables |
| loIn | input | W | Low port pin input values |
| loOut | output | W | Low port pin output values |
| loOe | output | W | Low port output enables |
| stra | input | 1 | Input handshake line |
| strb | output | 1 | Output strobe line |

## Verification
Register writes and `stra` edges take effect at the next rising edge, so `hiOut`, the flag and the latch are checked at the falling edge just after it. A strobe is checked as active at that falling edge and idle one cycle later. Read data is combinational, so it is sampled before the rising edge that ends the read. Bus cycles are checked at the falling edges one and two cycles after `busStart`, and captured read data is checked one cycle after the data phase. All inputs are driven at falling edges.

// File: rtl/ppair_pkg.sv
package ppair_pkg;
  typedef enum logic [1:0] {BUS_IDLE, BUS_ADDR, BUS_DATA} busPhase_t;

  typedef struct packed {
    logic edgeRise;
    logic strbInv;
    logic hsEn;
    logic strobedEn;
  } portCfg_t;

  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic wrDdr;
    logic wrCfg;
    logic rdLatch;
    logic capture;
    logic fireStrb;
    logic busLoad;
    logic busCapture;
  } ctrlStrb_t;
endpackage

// File: rtl/ppair_ctrl.sv
module ppair_ctrl
  import ppair_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      expMode,
  input  logic [1:0] regSel,
  input  logic      regWr,
  input  logic      regRd,
  input  logic      busStart,
  input  logic      stra,
  input  portCfg_t  cfg,
  output ctrlStrb_t st,
  output busPhase_t phase
);
  logic straQ;
  logic straEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      straQ <= 1'b0;
      phase <= BUS_IDLE;
    end else begin
      straQ <= stra;
      if (!expMode) phase <= BUS_IDLE;
      else begin
        unique case (phase)
          BUS_IDLE: if (busStart) phase <= BUS_ADDR;
          BUS_ADDR: phase <= BUS_DATA;
          default:  phase <= BUS_IDLE;
        endcase
      end
    end
  end

  assign straEdge = cfg.edgeRise ? (stra & ~straQ) : (~stra & straQ);

  always_comb begin
    st = '0;
    st.wrHi       = regWr && regSel == 2'd0 && !expMode;
    st.wrLo       = regWr && regSel == 2'd1;
    st.wrDdr      = regWr && regSel == 2'd2;
    st.wrCfg      = regWr && regSel == 2'd3;
    st.rdLatch    = regRd && regSel == 2'd1 && cfg.hsEn && !expMode;
    st.capture    = straEdge && cfg.hsEn && !expMode;
    st.fireStrb   = (st.wrHi && cfg.strobedEn) || st.rdLatch;
    st.busLoad    = expMode && phase == BUS_IDLE && busStart;
    st.busCapture = expMode && phase == BUS_DATA;
  end
endmodule

// File: rtl/ppair_dp.sv
module ppair_dp
  import ppair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          expMode,
  input  ctrlStrb_t     st,
  input  busPhase_t     phase,
  input  logic [1:0]    regSel,
  input  logic [W-1:0]  regWdata,
  output logic [W-1:0]  regRdata,
  input  logic          busRnW,
  input  logic [2*W-1:0] busAddr,
  input  logic [W-1:0]  busWdata,
  output logic [W-1:0]  busRdata,
  output logic          addrStrobe,
  output logic [W-1:0]  hiOut,
  output logic [W-1:0]  hiOe,
  input  logic [W-1:0]  loIn,
  output logic [W-1:0]  loOut,
  output logic [W-1:0]  loOe,
  output logic          strb,
  output portCfg_t      cfg
);
  localparam int AW   = 2 * W;
  localparam int PADW = W - 5;

  logic [W-1:0]  hiReg, loReg, ddrReg, latchQ, busWdQ, busRdQ;
  logic [AW-1:0] busAddrQ;
  logic          busRnwQ, flagQ, strbQ;
  portCfg_t      cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0; loReg <= '0; ddrReg <= '0; latchQ <= '0;
      busWdQ <= '0; busRdQ <= '0; busAddrQ <= '0;
      busRnwQ <= 1'b0; flagQ <= 1'b0; strbQ <= 1'b0; cfgQ <= '0;
    end else begin
      if (st.wrHi)  hiReg  <= regWdata;
      if (st.wrLo)  loReg  <= regWdata;
      if (st.wrDdr) ddrReg <= regWdata;
      if (st.wrCfg) cfgQ   <= portCfg_t'(regWdata[3:0]);
      if (st.capture) begin
        latchQ <= loIn;
        flagQ  <= 1'b1;
      end else if (st.rdLatch) flagQ <= 1'b0;
      strbQ <= st.fireStrb;
      if (st.busLoad) begin
        busAddrQ <= busAddr;
        busWdQ   <= busWdata;
        busRnwQ  <= busRnW;
      end
      if (st.busCapture && busRnwQ) busRdQ <= loIn;
    end
  end

  assign cfg        = cfgQ;
  assign strb       = strbQ ^ cfgQ.strbInv;
  assign busRdata   = busRdQ;
  assign hiOe       = '1;
  assign hiOut      = expMode ? busAddrQ[AW-1:W] : hiReg;
  assign addrStrobe = expMode && phase == BUS_ADDR;

  always_comb begin
    if (!expMode) begin
      loOut = loReg;
      loOe  = ddrReg;
    end else if (phase == BUS_ADDR) begin
      loOut = busAddrQ[W-1:0];
      loOe  = '1;
    end else if (phase == BUS_DATA) begin
      loOut = busWdQ;
      loOe  = busRnwQ ? '0 : '1;
    end else begin
      loOut = '0;
      loOe  = '0;
    end
  end

  always_comb begin
    unique case (regSel)
      2'd0: regRdata = hiReg;
      2'd1: regRdata = cfgQ.hsEn ? latchQ : ((loIn & ~ddrReg) | (loReg & ddrReg));
      2'd2: regRdata = ddrReg;
      default: regRdata = {flagQ, {PADW{1'b0}}, cfgQ};
    endcase
  end
endmodule

// File: rtl/ppair_top.sv
module ppair_top
  import ppair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           expMode,
  input  logic [1:0]     regSel,
  input  logic           regWr,
  input  logic           regRd,
  input  logic [W-1:0]   regWdata,
  output logic [W-1:0]   regRdata,
  input  logic           busStart,
  input  logic           busRnW,
  input  logic [2*W-1:0] busAddr,
  input  logic [W-1:0]   busWdata,
  output logic [W-1:0]   busRdata,
  output logic           addrStrobe,
  output logic [W-1:0]   hiOut,
  output logic [W-1:0]   hiOe,
  input  logic [W-1:0]   loIn,
  output logic [W-1:0]   loOut,
  output logic [W-1:0]   loOe,
  input  logic           stra,
  output logic           strb
);
  ctrlStrb_t stW;
  busPhase_t phaseW;
  portCfg_t  cfgW;

  ppair_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .expMode(expMode), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .busStart(busStart), .stra(stra),
    .cfg(cfgW), .st(stW), .phase(phaseW)
  );

  ppair_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .expMode(expMode), .st(stW), .phase(phaseW),
    .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .busRnW(busRnW), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .addrStrobe(addrStrobe), .hiOut(hiOut),
    .hiOe(hiOe), .loIn(loIn), .loOut(loOut), .loOe(loOe), .strb(strb),
    .cfg(cfgW)
  );
endmodule

// File: rtl/ppair_chk.sv
module ppair_chk
  import ppair_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           expMode,
  input logic [1:0]     regSel,
  input logic           regWr,
  input logic           regRd,
  input logic [W-1:0]   regWdata,
  input logic           busStart,
  input logic           busRnW,
  input logic [2*W-1:0] busAddr,
  input logic           addrStrobe,
  input logic [W-1:0]   hiOut,
  input logic [W-1:0]   loOut,
  input logic [W-1:0]   loOe,
  input logic           strb,
  input portCfg_t       cfg
);
  AST_STRB_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (strb ^ cfg.strbInv) |-> $past(!expMode && ((regWr && regSel == 2'd0 && cfg.strobedEn) || (regRd && regSel == 2'd1 && cfg.hsEn)))); // R3

  AST_HI_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!expMode && $past(!expMode && regWr && regSel == 2'd0)) |-> hiOut == $past(regWdata)); // R2

  AST_ADDR_PHASE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |-> ({hiOut, loOut} == $past(busAddr) && loOe == '1 && $past(busStart))); // R8

  AST_DATA_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (expMode && $past(expMode) && $past(addrStrobe)) |-> ((loOe == '0) == $past(busRnW, 2))); // R9
endmodule

bind ppair_top ppair_chk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .expMode(expMode), .regSel(regSel), .regWr(regWr),
  .regRd(regRd), .regWdata(regWdata), .busStart(busStart), .busRnW(busRnW),
  .busAddr(busAddr), .addrStrobe(addrStrobe), .hiOut(hiOut), .loOut(loOut),
  .loOe(loOe), .strb(strb), .cfg(cfgW)
);

// File: tb/ppair_top_tb_top.sv
module ppair_top_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic expMode = 1'b0;
  logic [1:0] regSel = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [W-1:0] regWdata = '0, regRdata;
  logic busStart = 1'b0, busRnW = 1'b0;
  logic [2*W-1:0] busAddr = '0;
  logic [W-1:0] busWdata = '0, busRdata;
  logic addrStrobe, strb, stra = 1'b0;
  logic [W-1:0] hiOut, hiOe, loIn = '0, loOut, loOe;

  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  ppair_top #(.W(W)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [W-1:0] d);
    regSel = s; regWdata = d; regWr = 1'b1;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] s, output logic [W-1:0] d);
    regSel = s; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic testReset();
    logic [W-1:0] d;
    chk("R1 hiOut", hiOut, 0); chk("R1 loOe", loOe, 0);
    chk("R1 strb", strb, 0);   chk("R1 addrStrobe", addrStrobe, 0);
    for (int i = 0; i < 4; i++) begin
      rdReg(i[1:0], d); chk("R1 regread", d, 0);
    end
  endtask

  task automatic testPlainOut();
    chk("R2 hiOe", hiOe, 8'hFF);
    wrReg(2'd0, 8'hA5);
    chk("R2 hiOut", hiOut, 8'hA5);
    chk("R3 no pulse when disabled", strb, 0);
  endtask

  task automatic testStrobed();
    wrReg(2'd3, 8'h01);
    wrReg(2'd0, 8'h3C);
    chk("R3 pulse active", strb, 1); chk("R2 hiOut", hiOut, 8'h3C);
    @(negedge clk); chk("R3 pulse one cycle", strb, 0);
    wrReg(2'd3, 8'h05);
    chk("R4 inverted idle", strb, 1);
    wrReg(2'd0, 8'h11);
    chk("R4 inverted pulse", strb, 0);
    @(negedge clk); chk("R4 inverted idle after", strb, 1);
    wrReg(2'd3, 8'h00);
  endtask

  task automatic testDir();
    logic [W-1:0] d;
    wrReg(2'd2, 8'hF0);
    wrReg(2'd1, 8'hAB);
    chk("R5 loOe", loOe, 8'hF0); chk("R5 loOut", loOut, 8'hAB);
    loIn = 8'h36;
    rdReg(2'd1, d); chk("R5 mixed read", d, 8'hA6);
  endtask

  task automatic testHandshake();
    logic [W-1:0] d;
    wrReg(2'd3, 8'h0A);
    loIn = 8'h5E; stra = 1'b1;
    @(posedge clk); @(negedge clk);
    loIn = 8'h00;
    rdReg(2'd3, d); chk("R6 flag set rising", d[7], 1);
    rdReg(2'd1, d); chk("R7 latch value", d, 8'h5E);
    chk("R7 strb pulse", strb, 1);
    rdReg(2'd3, d); chk("R7 flag cleared", d[7], 0);
    wrReg(2'd3, 8'h02);
    loIn = 8'h77; stra = 1'b0;
    @(posedge clk); @(negedge clk);
    loIn = 8'h01;
    rdReg(2'd3, d); chk("R6 flag set falling", d[7], 1);
    stra = 1'b1; @(posedge clk); @(negedge clk);
    rdReg(2'd1, d); chk("R6 rising ignored in falling mode", d, 8'h77);
    wrReg(2'd3, 8'h00);
  endtask

  task automatic busCycle(input logic rnw, input logic [15:0] a, input logic [W-1:0] wd);
    expMode = 1'b1; busStart = 1'b1; busRnW = rnw; busAddr = a; busWdata = wd;
    @(posedge clk); @(negedge clk);
    busStart = 1'b0;
    chk("R8 addrStrobe", addrStrobe, 1);
    chk("R8 address", {hiOut, loOut}, a);
    chk("R8 loOe", loOe, 8'hFF);
    loIn = 8'hC3;
    @(posedge clk); @(negedge clk);
    chk("R9 addrStrobe low", addrStrobe, 0);
    chk("R9 hiOut held", hiOut, a[15:8]);
    if (rnw) chk("R9 read loOe", loOe, 0);
    else begin
      chk("R9 write loOe", loOe, 8'hFF); chk("R9 write data", loOut, wd);
    end
    @(negedge clk);
    if (rnw) chk("R9 read capture", busRdata, 8'hC3);
  endtask

  task automatic testExpanded();
    busCycle(1'b0, 16'hBEEF, 8'h5A);
    busCycle(1'b1, 16'h1234, 8'h00);
    wrReg(2'd3, 8'h01);
    wrReg(2'd0, 8'h77);
    chk("R10 no strobe", strb, 0);
    expMode = 1'b0;
    #1 chk("R10 register kept", hiOut, 8'h11);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testPlainOut();
        testStrobed();
        testDir();
        testHandshake();
        testExpanded();
      end
      begin
        repeat (5000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule